// File: doc/BRIEF.md
# Asymmetric Converter Clock Prescaler

This block derives a slow converter clock from the system clock. The output wave has a high phase and a low phase whose lengths, counted in system-clock cycles, are set independently. The duty cycle can therefore be anything the two fields allow. Each field holds its phase length minus one: a 5-bit field sets the high phase and a 3-bit field sets the low phase. One legacy prescaler-add bit is accepted and stored but has no effect on the wave.

The output level comes straight from a register, so it has no glitches. Two one-cycle enable strobes mark each rising and each falling transition, so logic that runs on the system clock can act on converter-clock edges without a second clock domain.

New field values take effect only at a period boundary, on the edge where the wave goes from low to high. A period already under way keeps its length. As a worked case, a high field of 11 and a low field of 7 give a 20-cycle period, which turns 40 MHz into 2.0 MHz. Fields of 7 and 7 give 16 cycles, which turns 32 MHz into 2.0 MHz. The smallest setting, 0 and 0, divides by two, so the system clock always runs at least twice as fast as the output.

Top module: `cclk_prescaler`

## Requirements
- R1: While reset is asserted, the output level and both strobes are low one cycle after each reset edge, and the field inputs are captured as the active setting.
- R2: After reset is released, the output level first reads high on the (low field + 1)-th rising clock edge that follows the release.
- R3: Every high phase lasts exactly (high field + 1) system-clock cycles, using the 5-bit field value that was active at the start of that period.
- R4: Every low phase lasts exactly (low field + 1) system-clock cycles, using the 3-bit field value that was active when the period began.
- R5: The output period equals (high field + 1) + (low field + 1). Fields 11/7 give 12 high and 8 low (20 cycles); fields 7/7 give 8 and 8 (16 cycles).
- R6: Fields 0/0 give a divide-by-2 wave: one cycle high, one cycle low.
- R7: Fields 31/7 give 32 cycles high and 8 cycles low.
- R8: Field inputs are sampled only on the edge where the output goes from low to high. Changes made during a period alter neither of its phases and take effect from the next period.
- R9: The rise strobe is high for exactly one cycle, the first cycle in which the output reads high, and at no other time.
- R10: The fall strobe is high for exactly one cycle, the first cycle in which the output reads low after a high phase, and at no other time.
- R11: The legacy prescaler-add bit has no effect on the phase lengths or on the strobes, whether it is held at 0, held at 1, or changed in the middle of a phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hi_cnt_i | input | 5 | High-phase length minus one, in system-clock cycles |
| lo_cnt_i | input | 3 | Low-phase length minus one, in system-clock cycles |
| legacy_add_i | input | 1 | Legacy prescaler-add bit; stored, no effect |
| cclk_o | output | 1 | Divided converter clock level (registered) |
| rise_stb_o | output | 1 | One-cycle strobe on the first high cycle |
| fall_stb_o | output | 1 | One-cycle strobe on the first low cycle |

## Verification
The phase-length properties build their own copy of the active setting. They take for granted that the field inputs are settled before the clock edge on which a low-to-high transition happens, and that reset is asserted from time zero for at least one edge, so that the copy starts from the same values the block captured. The bench changes fields only at falling clock edges, holds reset from the start, and changes fields in mid-period only within a phase that is already under way. These are exactly the moments the boundary latch must ignore, so the assumptions hold while the pickup rule is still exercised.

// File: rtl/cclk_prescaler_pkg.sv
package cclk_prescaler_pkg;

    localparam int unsigned CCLK_HI_W = 5;
    localparam int unsigned CCLK_LO_W = 3;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } cclk_phase_e;

endpackage

// File: rtl/cclk_cfg_hold.sv
// Holds the active phase lengths; reloads them while in reset and at
// each period boundary flagged by the phase generator.
module cclk_cfg_hold #(
    parameter int unsigned HI_W = cclk_prescaler_pkg::CCLK_HI_W,
    parameter int unsigned LO_W = cclk_prescaler_pkg::CCLK_LO_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            load_i,
    input  logic [HI_W-1:0] hi_cnt_i,
    input  logic [LO_W-1:0] lo_cnt_i,
    input  logic            legacy_add_i,
    output logic [HI_W-1:0] hi_act_o,
    output logic [LO_W-1:0] lo_act_o
);

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic legacy_unused_d, legacy_unused_q;

    always_comb begin
        cfg_d           = cfg_q;
        legacy_unused_d = legacy_unused_q;
        if (rst_i || load_i) begin
            cfg_d.hi        = hi_cnt_i;
            cfg_d.lo        = lo_cnt_i;
            legacy_unused_d = legacy_add_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q           <= cfg_d;
        legacy_unused_q <= legacy_unused_d;
    end

    assign hi_act_o = cfg_q.hi;
    assign lo_act_o = cfg_q.lo;

endmodule

// File: rtl/cclk_phase_gen.sv
// Counts the cycles of each phase, toggles the level and raises the
// edge strobes together with the level change.
module cclk_phase_gen
    import cclk_prescaler_pkg::*;
#(
    parameter int unsigned HI_W = CCLK_HI_W,
    parameter int unsigned LO_W = CCLK_LO_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [HI_W-1:0] hi_act_i,
    input  logic [LO_W-1:0] lo_act_i,
    output logic            load_o,
    output logic            level_o,
    output logic            rise_o,
    output logic            fall_o
);

    localparam int unsigned CNT_W = (HI_W > LO_W) ? HI_W : LO_W;

    typedef struct packed {
        cclk_phase_e      ph;
        logic [CNT_W-1:0] cnt;
        logic             rise;
        logic             fall;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [CNT_W-1:0] hi_lim;
    logic [CNT_W-1:0] lo_lim;
    logic             boundary;

    assign hi_lim = CNT_W'(hi_act_i);
    assign lo_lim = CNT_W'(lo_act_i);

    always_comb begin
        gen_d      = gen_q;
        gen_d.rise = 1'b0;
        gen_d.fall = 1'b0;
        boundary   = 1'b0;
        if (rst_i) begin
            gen_d.ph  = PH_LOW;
            gen_d.cnt = '0;
        end else begin
            unique case (gen_q.ph)
                PH_LOW: begin
                    if (gen_q.cnt == lo_lim) begin
                        gen_d.ph   = PH_HIGH;
                        gen_d.cnt  = '0;
                        gen_d.rise = 1'b1;
                        boundary   = 1'b1;
                    end else begin
                        gen_d.cnt = gen_q.cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (gen_q.cnt == hi_lim) begin
                        gen_d.ph   = PH_LOW;
                        gen_d.cnt  = '0;
                        gen_d.fall = 1'b1;
                    end else begin
                        gen_d.cnt = gen_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    gen_d.ph  = PH_LOW;
                    gen_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        gen_q <= gen_d;
    end

    assign load_o  = boundary;
    assign level_o = (gen_q.ph == PH_HIGH);
    assign rise_o  = gen_q.rise;
    assign fall_o  = gen_q.fall;

endmodule

// File: rtl/cclk_prescaler.sv
module cclk_prescaler
    import cclk_prescaler_pkg::*;
#(
    parameter int unsigned HI_W = CCLK_HI_W,
    parameter int unsigned LO_W = CCLK_LO_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [HI_W-1:0] hi_cnt_i,
    input  logic [LO_W-1:0] lo_cnt_i,
    input  logic            legacy_add_i,
    output logic            cclk_o,
    output logic            rise_stb_o,
    output logic            fall_stb_o
);

    logic [HI_W-1:0] hi_act;
    logic [LO_W-1:0] lo_act;
    logic            load;

    cclk_cfg_hold #(
        .HI_W(HI_W),
        .LO_W(LO_W)
    ) u_cfg (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .load_i       (load),
        .hi_cnt_i     (hi_cnt_i),
        .lo_cnt_i     (lo_cnt_i),
        .legacy_add_i (legacy_add_i),
        .hi_act_o     (hi_act),
        .lo_act_o     (lo_act)
    );

    cclk_phase_gen #(
        .HI_W(HI_W),
        .LO_W(LO_W)
    ) u_gen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .hi_act_i (hi_act),
        .lo_act_i (lo_act),
        .load_o   (load),
        .level_o  (cclk_o),
        .rise_o   (rise_stb_o),
        .fall_o   (fall_stb_o)
    );

endmodule

// File: rtl/cclk_prescaler_chk.sv
module cclk_prescaler_chk #(
    parameter int unsigned HI_W = 5,
    parameter int unsigned LO_W = 3
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [HI_W-1:0] hi_cnt_i,
    input logic [LO_W-1:0] lo_cnt_i,
    input logic            cclk_o,
    input logic            rise_stb_o,
    input logic            fall_stb_o
);

    localparam int unsigned RUN_W = ((HI_W > LO_W) ? HI_W : LO_W) + 1;

    logic [HI_W-1:0]  hi_prev_q, act_hi_q;
    logic [LO_W-1:0]  lo_prev_q, act_lo_q;
    logic             lvl_q;
    logic [RUN_W-1:0] run_q;

    // Independent model of the active setting and of the run length.
    always_ff @(posedge clk_i) begin
        hi_prev_q <= hi_cnt_i;
        lo_prev_q <= lo_cnt_i;
        if (rst_i) begin
            act_hi_q <= hi_cnt_i;
            act_lo_q <= lo_cnt_i;
            lvl_q    <= 1'b0;
            run_q    <= '0;
        end else begin
            if (rise_stb_o) begin
                act_hi_q <= hi_prev_q;
                act_lo_q <= lo_prev_q;
            end
            lvl_q <= cclk_o;
            run_q <= (cclk_o == lvl_q) ? run_q + RUN_W'(1) : RUN_W'(1);
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        rst_i |=> (!cclk_o && !rise_stb_o && !fall_stb_o));

    p_rise_on_edge_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_stb_o == (cclk_o && !$past(cclk_o)));

    p_fall_on_edge_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_stb_o == (!cclk_o && $past(cclk_o)));

    p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rise_stb_o && fall_stb_o));

    // R3 and R8: high run closed by a fall matches the setting taken at its rise
    p_high_len_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        fall_stb_o |-> (run_q == RUN_W'(act_hi_q) + RUN_W'(1)));

    // R4 and R8: low run closed by a rise matches the setting of its period
    p_low_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_stb_o && lvl_q == 1'b0 && run_q != '0) |->
        (run_q == RUN_W'(act_lo_q) + RUN_W'(1)));

endmodule

bind cclk_prescaler cclk_prescaler_chk #(
    .HI_W(HI_W),
    .LO_W(LO_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hi_cnt_i   (hi_cnt_i),
    .lo_cnt_i   (lo_cnt_i),
    .cclk_o     (cclk_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o)
);

// File: tb/cclk_prescaler_tb.sv
`timescale 1ns/1ps
module cclk_prescaler_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] hi_cnt = 5'd2;
    logic [2:0] lo_cnt = 3'd5;
    logic       legacy = 1'b0;
    logic       cclk, rise_stb, fall_stb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cclk_prescaler dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .hi_cnt_i     (hi_cnt),
        .lo_cnt_i     (lo_cnt),
        .legacy_add_i (legacy),
        .cclk_o       (cclk),
        .rise_stb_o   (rise_stb),
        .fall_stb_o   (fall_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!rise_stb);
    endtask

    // Starts on a first-high cycle, ends on the next first-high cycle.
    task automatic measure(output int hn, output int ln, output int bad,
                           output bit fall_ok, output bit rise_ok);
        hn = 0; ln = 0; bad = 0;
        while (cclk) begin
            if (hn > 0 && rise_stb) bad++;
            if (fall_stb) bad++;
            hn++;
            @(negedge clk);
        end
        fall_ok = fall_stb;
        while (!cclk) begin
            if (ln > 0 && fall_stb) bad++;
            if (rise_stb) bad++;
            ln++;
            @(negedge clk);
        end
        rise_ok = rise_stb;
    endtask

    task automatic t_reset();
        int n;
        hi_cnt = 5'd2; lo_cnt = 3'd5; rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cclk && !rise_stb && !fall_stb, "R1", "outputs low in reset",
            {cclk, rise_stb, fall_stb}, 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!cclk && n < 40);
        chk(n == 6, "R2", "edges to first rise", n, 6);
        chk(rise_stb, "R9", "rise strobe on first high", rise_stb, 1);
    endtask

    task automatic t_shape(input int h, input int l, input string req);
        int hn, ln, bad; bit fo, ro;
        hi_cnt = 5'(h); lo_cnt = 3'(l);
        wait_rise();
        measure(hn, ln, bad, fo, ro);
        chk(hn == h + 1, req, "high cycles (R3)", hn, h + 1);
        chk(ln == l + 1, req, "low cycles (R4)", ln, l + 1);
        chk(hn + ln == h + l + 2, "R5", "period", hn + ln, h + l + 2);
        chk(bad == 0, "R9", "stray strobes", bad, 0);
        chk(fo, "R10", "fall strobe on first low", fo, 1);
    endtask

    task automatic t_midchange();
        int hn, ln, bad; bit fo, ro;
        hi_cnt = 5'd3; lo_cnt = 3'd2;
        wait_rise();
        measure(hn, ln, bad, fo, ro);
        hi_cnt = 5'd9; lo_cnt = 3'd6;
        measure(hn, ln, bad, fo, ro);
        chk(hn == 4, "R8", "high after mid change", hn, 4);
        chk(ln == 3, "R8", "low after mid change", ln, 3);
        measure(hn, ln, bad, fo, ro);
        chk(hn == 10, "R8", "high next period", hn, 10);
        chk(ln == 7, "R8", "low next period", ln, 7);
        chk(bad == 0 && ro, "R9", "strobes across change", bad, 0);
    endtask

    task automatic t_legacy();
        int hn, ln, bad; bit fo, ro;
        hi_cnt = 5'd4; lo_cnt = 3'd5; legacy = 1'b0;
        wait_rise();
        legacy = 1'b1;
        measure(hn, ln, bad, fo, ro);
        chk(hn == 5 && ln == 6, "R11", "legacy set, high+low", hn * 100 + ln, 506);
        measure(hn, ln, bad, fo, ro);
        chk(hn == 5 && ln == 6, "R11", "legacy held, high+low", hn * 100 + ln, 506);
        chk(bad == 0 && fo && ro, "R11", "legacy strobes", bad, 0);
        legacy = 1'b0;
    endtask

    initial begin
        t_reset();
        t_shape(2, 5, "R3");
        t_shape(11, 7, "R5");
        t_shape(7, 7, "R5");
        t_shape(0, 0, "R6");
        t_shape(31, 7, "R7");
        t_shape(0, 7, "R4");
        t_midchange();
        t_legacy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule